// File: doc/BRIEF.md
# Serial Shift Transceiver with Selectable Clock Source

This block moves one byte at a time over a three-wire synchronous serial link (clock, data in, data out). Software loads a byte, pulses a start strobe, and the block exchanges eight bits with its peer. When the exchange is over it reads the received byte back in parallel. A configuration bit picks the role. As clock source, the block drives SCK itself from the system clock through a divider of 2, 4, 8 or 16. As clock follower, it takes SCK from an external pin. No select line frames a byte, so the block frames each one by counting clock edges. The byte ends on the eighth rising edge.

The serial clock rests high. A falling edge puts the next bit on SDO, most significant bit first. A rising edge captures SDI. In follower mode the external SCK and SDI pass through a two-stage synchronizer, and edges are found in the system clock domain. The external clock therefore must run no faster than a quarter of the system clock. A busy flag covers the exchange. A complete flag reports a finished byte until the next start or a read of the received data.

Top module: `ser_xcvr`

## Requirements
- R1: With `slave_mode` = 0 the block drives `sck_out` and holds `sck_oe` = 1. With `slave_mode` = 1, `sck_oe` = 0 and the transfer is clocked by edges on `sck_in`, seen after the two-stage synchronizer.
- R2: In source mode `sck_out` is 1 whenever no transfer is in progress.
- R3: Each falling SCK edge of a transfer drives the next transmit bit onto `sdo`, most significant bit first. `sdo` changes at no other time, so it keeps the last bit between transfers.
- R4: Each rising SCK edge of a transfer samples `sdi`. The first sample becomes bit 7 of the received byte.
- R5: On the eighth rising edge `busy` drops, `done` rises and `rx_data` shows the eight sampled bits.
- R6: In source mode SCK stays low for 2^`rate_sel` system cycles and high for the same time. This makes the SCK period 2, 4, 8 or 16 system cycles for `rate_sel` 0, 1, 2 or 3.
- R7: `done` clears on an accepted `start` or on an `rx_read` pulse. A completion in the same cycle as `rx_read` leaves `done` set.
- R8: While `busy` = 1, `tx_write` does not change the transmit byte and `start` does not restart the transfer.
- R9: After reset `sdo` = 1, `sck_out` = 1, `busy` = 0, `done` = 0 and `rx_data` = 0.
- R10: In follower mode, SCK edges that arrive with no transfer started leave `busy`, `done`, `sdo` and `rx_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slave_mode | input | 1 | 0: block drives SCK, 1: SCK comes from `sck_in` |
| rate_sel | input | 2 | Source-mode SCK divider select, static |
| tx_data | input | 8 | Byte to transmit |
| tx_write | input | 1 | Load `tx_data` into the transmit buffer |
| start | input | 1 | Begin a transfer of the buffered byte |
| rx_read | input | 1 | Read strobe for `rx_data`, clears `done` |
| rx_data | output | 8 | Last received byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer complete flag |
| sck_in | input | 1 | External serial clock (follower mode) |
| sck_out | output | 1 | Generated serial clock (source mode) |
| sck_oe | output | 1 | Drive enable for `sck_out` |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
A bit counter that is off by one shows within one byte. The byte returned on `rx_data` is then shifted, the bits seen on `sdo` drift against the peer's clock, and `busy` drops one SCK period early or late. A wrong divider count shows on the first low phase of `sck_out`, within 16 system cycles of a start. A stale transmit buffer or a restart taken while busy corrupts the byte seen on `sdo` in that same transfer. A follower that reacts while not started moves `sdo` or raises `busy` within three system cycles of an external edge.

// File: rtl/ser_pkg.sv
package ser_pkg;

  localparam int unsigned RATE_W = 2;

  // Clock events in the system domain, one cycle wide.
  typedef struct packed {
    logic fall;
    logic rise;
  } sck_evt_t;

  // System cycles per SCK half period for a divider select.
  function automatic int unsigned half_period(input logic [RATE_W-1:0] sel);
    return 32'd1 << sel;
  endfunction

  // Largest half period any select can ask for.
  function automatic int unsigned max_half_period();
    return 32'd1 << ((32'd1 << RATE_W) - 1);
  endfunction

endpackage

// File: rtl/ser_clkgen.sv
module ser_clkgen
  import ser_pkg::*;
#(
  parameter int unsigned SEL_W = RATE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [SEL_W-1:0] rate_i,
  output logic             sck_o,
  output sck_evt_t         evt_o
);

  localparam int unsigned MAX_HALF = max_half_period();
  localparam int unsigned CNT_W    = $clog2(MAX_HALF) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half;
  logic             sck_q;
  logic             tick;

  assign half = CNT_W'(half_period(rate_i));
  assign tick = run_i && (cnt_q == half - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (!run_i) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (tick) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign sck_o      = sck_q;
  assign evt_o.fall = tick && sck_q;
  assign evt_o.rise = tick && !sck_q;

  // R2: the clock returns to its idle level once a transfer stops
  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> sck_q);

  // R6: the phase counter never passes the selected half period
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < half));

endmodule

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int unsigned W       = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/ser_core.sv
module ser_core
  import ser_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sck_evt_t          evt_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_write_i,
  input  logic              start_i,
  input  logic              rx_read_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              sdo_o
);

  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] txbuf_q, shreg_q, rxbuf_q;
  logic [CNT_W-1:0]  bitcnt_q;
  logic              busy_q, done_q, sdo_q;

  // Named internal events
  logic              accept_start, accept_wr;
  logic              shift_fall, shift_rise, last_rise;
  logic [DATA_W-1:0] load_val, shifted;

  assign accept_start = start_i && !busy_q;
  assign accept_wr    = tx_write_i && !busy_q;
  assign shift_fall   = evt_i.fall && busy_q;
  assign shift_rise   = evt_i.rise && busy_q;
  assign last_rise    = shift_rise && (bitcnt_q == LAST);
  assign load_val     = accept_wr ? tx_data_i : txbuf_q;
  assign shifted      = {shreg_q[DATA_W-2:0], sdi_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txbuf_q  <= '0;
      shreg_q  <= '0;
      rxbuf_q  <= '0;
      bitcnt_q <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      sdo_q    <= 1'b1;
    end else begin
      if (accept_wr) txbuf_q <= tx_data_i;
      if (accept_start) begin
        shreg_q  <= load_val;
        bitcnt_q <= '0;
        busy_q   <= 1'b1;
        done_q   <= 1'b0;
      end else begin
        if (shift_fall) sdo_q <= shreg_q[DATA_W-1];
        if (shift_rise) begin
          shreg_q  <= shifted;
          bitcnt_q <= (bitcnt_q == LAST) ? '0 : bitcnt_q + CNT_W'(1);
        end
        if (last_rise) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          rxbuf_q <= shifted;
        end else if (rx_read_i) begin
          done_q <= 1'b0;
        end
      end
    end
  end

  assign rx_data_o = rxbuf_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign sdo_o     = sdo_q;

  // R3: serial output moves only on a falling edge inside a transfer
  p_sdo_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_fall |=> $stable(sdo_q));

  // R5: the final rising edge ends the transfer and flags it
  p_last_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    last_rise |=> (done_q && !busy_q));

  // R5: complete and busy are never seen together
  p_busy_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q));

  // R7: an accepted start clears the complete flag
  p_start_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept_start |=> (busy_q && !done_q));

  // R7: a read with no completion in the same cycle clears the flag
  p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_read_i && !last_rise) |=> !done_q);

  // R8: writes during a transfer leave the buffer alone
  p_wr_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_write_i && busy_q) |=> $stable(txbuf_q));

  // R8: a start during a transfer does not reset the bit count
  p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_q && !shift_rise) |=> $stable(bitcnt_q));

endmodule

// File: rtl/ser_xcvr.sv
module ser_xcvr
  import ser_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_mode,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_write,
  input  logic              start,
  input  logic              rx_read,
  output logic [DATA_W-1:0] rx_data,
  output logic              busy,
  output logic              done,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  input  logic              sdi,
  output logic              sdo
);

  sck_evt_t gen_evt, ext_evt, evt;
  logic     gen_run, gen_sck;
  logic     ext_sck, ext_sdi, ext_sck_prev_q;
  logic     sdi_sel;
  logic     busy_w;

  assign gen_run = busy_w && !slave_mode;

  ser_clkgen #(.SEL_W(RATE_W)) u_clkgen (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (gen_run),
    .rate_i (rate_sel),
    .sck_o  (gen_sck),
    .evt_o  (gen_evt)
  );

  ser_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({sck_in, sdi}),
    .q_o   ({ext_sck, ext_sdi})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_sck_prev_q <= 1'b1;
    else        ext_sck_prev_q <= ext_sck;
  end

  assign ext_evt.fall = ext_sck_prev_q && !ext_sck;
  assign ext_evt.rise = !ext_sck_prev_q && ext_sck;

  assign evt     = slave_mode ? ext_evt : gen_evt;
  assign sdi_sel = slave_mode ? ext_sdi : sdi;

  ser_core #(.DATA_W(DATA_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt),
    .sdi_i      (sdi_sel),
    .tx_data_i  (tx_data),
    .tx_write_i (tx_write),
    .start_i    (start),
    .rx_read_i  (rx_read),
    .rx_data_o  (rx_data),
    .busy_o     (busy_w),
    .done_o     (done),
    .sdo_o      (sdo)
  );

  assign busy    = busy_w;
  assign sck_out = gen_sck;
  assign sck_oe  = !slave_mode;

  // R1: in follower mode the internal divider never leaves idle
  p_follower_gen_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> !(gen_evt.fall || gen_evt.rise));

  // R10: external edges while idle never start a transfer
  p_idle_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_w && !start) |=> !busy_w);

endmodule

// File: tb/ser_xcvr_tb.sv
module ser_xcvr_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slave_mode = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_write = 1'b0, start = 1'b0, rx_read = 1'b0;
  logic [7:0] rx_data;
  logic       busy, done, sck_in = 1'b1, sck_out, sck_oe, sdi = 1'b1, sdo;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ser_xcvr u_dut (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .rate_sel(rate_sel),
    .tx_data(tx_data), .tx_write(tx_write), .start(start), .rx_read(rx_read),
    .rx_data(rx_data), .busy(busy), .done(done), .sck_in(sck_in),
    .sck_out(sck_out), .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected low time: oscillator divisor 2^(sel+1), half of it low.
  function automatic int exp_low(input logic [1:0] sel);
    int div = 2;
    for (int i = 0; i < sel; i++) div = div * 2;
    return div / 2;
  endfunction

  // Source-mode transfer; bench acts as the peer.
  task automatic master_xfer(input logic [1:0] sel, input logic [7:0] tx, input bit dowrite,
                             input logic [7:0] pin, input bit poke,
                             output logic [7:0] got, output int lowlen);
    int k = 0; int low = 0; int guard = 0; bit prev = 1'b1; bit poked = 1'b0;
    got = 8'h00; lowlen = 0;
    slave_mode = 1'b0; rate_sel = sel;
    @(negedge clk);
    if (dowrite) begin tx_data = tx; tx_write = 1'b1; @(negedge clk); tx_write = 1'b0; end
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk(busy && !done, "R7 start sets busy, clears done", {busy, done}, 2'b10);
    while (k < 8 && guard < 1000) begin
      guard++;
      if (prev && !sck_out) begin sdi = pin[7-k]; low = 1; end
      else if (!prev && sck_out) begin got[7-k] = sdo; k++; lowlen = low; end
      else if (!sck_out) low++;
      prev = sck_out;
      if (poke && k == 3 && !poked) begin
        tx_data = ~tx; tx_write = 1'b1; start = 1'b1; poked = 1'b1;
      end else begin
        tx_write = 1'b0; start = 1'b0;
      end
      @(negedge clk);
    end
    tx_write = 1'b0; start = 1'b0;
  endtask

  // Follower-mode transfer with a half period of hp system cycles.
  task automatic slave_xfer(input logic [7:0] tx, input logic [7:0] pin, input int hp,
                            output logic [7:0] got);
    got = 8'h00;
    slave_mode = 1'b1; sck_in = 1'b1;
    @(negedge clk);
    tx_data = tx; tx_write = 1'b1; start = 1'b1;
    @(negedge clk); tx_write = 1'b0; start = 1'b0;
    for (int k = 0; k < 8; k++) begin
      sck_in = 1'b0; sdi = pin[7-k];
      repeat (hp) @(negedge clk);
      got[7-k] = sdo;
      sck_in = 1'b1;
      repeat (hp) @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] got, tx, pin, last_tx;
    logic [1:0] sel;
    int lowlen;
    void'($urandom(32'h5EED_0042));

    repeat (3) @(negedge clk);
    // R9: reset state
    chk(sdo === 1'b1 && sck_out === 1'b1, "R9 reset sdo/sck", {sdo, sck_out}, 2'b11);
    chk(busy === 1'b0 && done === 1'b0 && rx_data === 8'h00, "R9 reset flags/data",
        {busy, done, rx_data}, 10'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sck_oe === 1'b1, "R1 source mode drives clock", sck_oe, 1);

    // Directed: every rate with fixed patterns
    for (int s = 0; s < 4; s++) begin
      tx = 8'hA5 ^ 8'(s); pin = 8'h3C + 8'(s);
      master_xfer(2'(s), tx, 1'b1, pin, 1'b0, got, lowlen);
      chk(got == tx, "R3 sdo bits MSB first", got, tx);
      chk(rx_data == pin && done && !busy, "R4 R5 received byte and flags", rx_data, pin);
      chk(lowlen == exp_low(2'(s)), "R6 SCK low time", lowlen, exp_low(2'(s)));
      chk(sck_out == 1'b1, "R2 idle high after transfer", sck_out, 1);
      repeat (5) @(negedge clk);
      chk(sdo == tx[0], "R3 sdo holds last bit", sdo, tx[0]);
      chk(sck_out == 1'b1, "R2 clock stays idle", sck_out, 1);
    end

    // R7: read clears done
    rx_read = 1'b1; @(negedge clk); rx_read = 1'b0;
    chk(done == 1'b0, "R7 read clears done", done, 0);

    // R8: write and start mid-transfer ignored; buffer kept for next start
    master_xfer(2'd2, 8'h96, 1'b1, 8'h0F, 1'b1, got, lowlen);
    chk(got == 8'h96, "R8 start/write while busy ignored", got, 8'h96);
    chk(rx_data == 8'h0F, "R8 receive unaffected", rx_data, 8'h0F);
    master_xfer(2'd0, 8'h00, 1'b0, 8'hE1, 1'b0, got, lowlen);
    chk(got == 8'h96, "R8 buffer not overwritten while busy", got, 8'h96);

    // Random source-mode transfers
    for (int n = 0; n < 20; n++) begin
      sel = 2'($urandom_range(0, 3)); tx = 8'($urandom); pin = 8'($urandom);
      master_xfer(sel, tx, 1'b1, pin, 1'b0, got, lowlen);
      chk(got == tx, "R3 random tx", got, tx);
      chk(rx_data == pin, "R4 random rx", rx_data, pin);
      chk(lowlen == exp_low(sel), "R6 random rate", lowlen, exp_low(sel));
      if (n % 4 == 0) begin rx_read = 1'b1; @(negedge clk); rx_read = 1'b0; end
    end

    // R10: follower mode, edges with no start are ignored
    slave_mode = 1'b1; last_tx = tx;
    @(negedge clk);
    chk(sck_oe == 1'b0, "R1 follower mode releases clock", sck_oe, 0);
    for (int k = 0; k < 6; k++) begin
      sck_in = 1'b0; sdi = ~sdi; repeat (4) @(negedge clk);
      sck_in = 1'b1; repeat (4) @(negedge clk);
    end
    chk(busy == 1'b0 && sdo == last_tx[0], "R10 idle edges ignored", {busy, sdo}, {1'b0, last_tx[0]});
    chk(rx_data == pin, "R10 rx_data unchanged", rx_data, pin);

    // Follower-mode transfers
    for (int n = 0; n < 10; n++) begin
      tx = (n == 0) ? 8'h81 : 8'($urandom); pin = (n == 0) ? 8'h7E : 8'($urandom);
      slave_xfer(tx, pin, 4 + (n % 3), got);
      chk(got == tx, "R1 R3 follower tx", got, tx);
      chk(rx_data == pin && done && !busy, "R4 R5 follower rx", rx_data, pin);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule